// File: doc/BRIEF.md
# Scatter-Gather Buffer Address Generator

This block turns a transfer buffer that is scattered over several physical memory pages into the stream of byte addresses a bus master needs as data moves. A descriptor load hands it a set of page base pointers, the byte offset at which the data starts inside the first page, and the total byte count of the transfer. After that, each advance request reports how many bytes were just moved. The block steps its in-page offset, moves on to the next page pointer when the offset runs past the end of a page, and counts the remaining bytes down.

The address is never produced by adding pointers. It is always the selected page base placed above the in-page offset. Pages are 4 KB, so the offset is 12 bits wide and a page pointer supplies address bits 31:12. There are five pointer slots. Software chooses only the starting offset, and every later page is entered at offset zero. One descriptor therefore spans at most 20 KB. A buffer that begins near the end of its first page is guaranteed only 16 KB. A request that would need a sixth page raises a sticky overflow error, and the outputs then hold still until the next load.

Top module: `sg_addr_gen`

## Requirements
- R1: A load sets the page index to 0, the offset to `offset_i`, the remaining count to `total_i`, and clears overflow. These values appear on the outputs one clock after the load. If a load and an advance arrive in the same cycle, the load wins and the advance is dropped.
- R2: `addr_o` is the selected page pointer in bits 31:12 and the 12-bit in-page offset in bits 11:0. Page slot k is taken from bits [20k+19:20k] of `page_ptrs_i`, and the pointers are captured on a load.
- R3: An advance whose new offset (offset + bytes) stays below 4096 adds the byte amount to the offset and subtracts it from the remaining count. If the byte amount exceeds the remaining count, the count stops at 0. An advance of zero bytes changes nothing.
- R4: An advance whose new offset reaches 4096 or more while the page index is below 4 increments the page index and sets the offset to the new offset minus 4096. The remaining count decrements as in R3.
- R5: `done_o` is high exactly when the remaining count is 0, which includes the state after reset. While it is high, an advance changes no output.
- R6: An advance larger than 4096 bytes raises overflow. So does an advance that reaches 4096 or more on page index 4 without ending the transfer exactly at the page end. Overflow then stays high, and the address, page index and remaining count hold until the next load, ignoring any advance.
- R7: An advance on page index 4 where the byte amount equals the remaining count and the new offset is exactly 4096 ends the transfer. The remaining count becomes 0, the page index and offset hold, and overflow stays low, so a full 20 KB buffer starting at offset 0 completes without error.
- R8: After reset, `addr_o`, `remain_o` and `page_idx_o` are 0, `overflow_o` is low and `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a new descriptor |
| page_ptrs_i | input | 100 | Five 20-bit page base pointers, slot 0 in the low bits |
| offset_i | input | 12 | Starting offset inside page slot 0 |
| total_i | input | 15 | Total byte count of the transfer |
| adv_i | input | 1 | Advance request |
| adv_bytes_i | input | 13 | Bytes moved by this advance |
| addr_o | output | 32 | Current physical byte address |
| remain_o | output | 15 | Bytes still to transfer |
| page_idx_o | output | 3 | Page pointer slot in use |
| done_o | output | 1 | Remaining count is zero |
| overflow_o | output | 1 | Sticky error: descriptor reach exceeded |

## Verification
The two functions that can fall in one cycle are the page crossing and the exhaustion of the byte count. They meet when an advance on the last page pointer carries the offset to the page end. Whether the result is a clean finish or an overflow depends on whether the bytes left match the advance exactly. The bench drives a full 20 KB transfer from offset 0 and a five-page walk from a non-zero offset. It judges the remaining count, page index, address and overflow flag on the edge after the closing advance. A load issued in the same cycle as an advance also checks that the load takes priority.

// File: rtl/sg_addr_pkg.sv
package sg_addr_pkg;

    // Outcome of one advance request, decided from the current state.
    typedef enum logic [2:0] {
        ADV_NONE   = 3'd0,  // no request
        ADV_SKIP   = 3'd1,  // request while count is exhausted
        ADV_INPAGE = 3'd2,  // stays inside the current page
        ADV_CROSS  = 3'd3,  // moves on to the next page slot
        ADV_END    = 3'd4,  // exact finish at the end of the last page
        ADV_ERR    = 3'd5   // needs a page beyond the last slot
    } adv_kind_e;

endpackage

// File: rtl/sg_sat_sub.sv
module sg_sat_sub #(
    parameter int W = 15
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        if (b_i >= a_i) begin
            y_o = '0;
        end else begin
            y_o = a_i - b_i;
        end
    end

endmodule

// File: rtl/sg_step_calc.sv
module sg_step_calc
    import sg_addr_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int NUM_PAGES = 5,
    parameter int IDX_W     = 3,
    parameter int LEN_W     = 15,
    parameter int STEP_W    = 13
) (
    input  logic                 adv_i,
    input  logic [STEP_W-1:0]    bytes_i,
    input  logic [PAGE_BITS-1:0] offset_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [LEN_W-1:0]     remain_i,
    output adv_kind_e            kind_o,
    output logic [PAGE_BITS-1:0] next_off_o
);

    localparam int SUM_W = ((STEP_W > PAGE_BITS) ? STEP_W : PAGE_BITS) + 1;
    localparam logic [SUM_W-1:0] PAGE_SIZE = SUM_W'(1) << PAGE_BITS;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_PAGES - 1);

    logic [SUM_W-1:0] sum;
    logic             oversize;
    logic             carry;
    logic             on_last;
    logic             exact_end;
    logic             exhausted;

    assign sum        = SUM_W'(offset_i) + SUM_W'(bytes_i);
    assign oversize   = SUM_W'(bytes_i) > PAGE_SIZE;
    assign carry      = sum >= PAGE_SIZE;
    assign on_last    = idx_i == LAST_IDX;
    assign exact_end  = (LEN_W'(bytes_i) == remain_i) && (sum == PAGE_SIZE);
    assign exhausted  = remain_i == '0;
    assign next_off_o = sum[PAGE_BITS-1:0];

    always_comb begin
        if (!adv_i) begin
            kind_o = ADV_NONE;
        end else if (exhausted) begin
            kind_o = ADV_SKIP;
        end else if (oversize) begin
            kind_o = ADV_ERR;
        end else if (carry && on_last) begin
            kind_o = exact_end ? ADV_END : ADV_ERR;
        end else if (carry) begin
            kind_o = ADV_CROSS;
        end else begin
            kind_o = ADV_INPAGE;
        end
    end

endmodule

// File: rtl/sg_page_bank.sv
module sg_page_bank #(
    parameter int PTR_W     = 20,
    parameter int NUM_PAGES = 5,
    parameter int IDX_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [NUM_PAGES*PTR_W-1:0] ptrs_i,
    input  logic [IDX_W-1:0]           idx_i,
    output logic [PTR_W-1:0]           ptr_o
);

    logic [PTR_W-1:0] slot_w [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_slot
        logic [PTR_W-1:0] ptr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q <= '0;
            end else if (load_i) begin
                ptr_q <= ptrs_i[g*PTR_W +: PTR_W];
            end
        end

        assign slot_w[g] = ptr_q;
    end

    always_comb begin
        ptr_o = '0;
        for (int k = 0; k < NUM_PAGES; k++) begin
            if (idx_i == IDX_W'(k)) begin
                ptr_o = slot_w[k];
            end
        end
    end

endmodule

// File: rtl/sg_addr_gen.sv
module sg_addr_gen
    import sg_addr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int NUM_PAGES = 5,
    parameter int LEN_W     = 15,
    parameter int STEP_W    = PAGE_BITS + 1,
    parameter int IDX_W     = $clog2(NUM_PAGES),
    parameter int PTR_W     = ADDR_W - PAGE_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [NUM_PAGES*PTR_W-1:0] page_ptrs_i,
    input  logic [PAGE_BITS-1:0]       offset_i,
    input  logic [LEN_W-1:0]           total_i,
    input  logic                       adv_i,
    input  logic [STEP_W-1:0]          adv_bytes_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [LEN_W-1:0]           remain_o,
    output logic [IDX_W-1:0]           page_idx_o,
    output logic                       done_o,
    output logic                       overflow_o
);

    typedef struct packed {
        logic [PAGE_BITS-1:0] offset;
        logic [IDX_W-1:0]     idx;
        logic [LEN_W-1:0]     remain;
        logic                 ovf;
    } walk_t;

    walk_t st_d, st_q;

    adv_kind_e            kind;
    logic [PAGE_BITS-1:0] next_off;
    logic [LEN_W-1:0]     rem_sub;
    logic [PTR_W-1:0]     cur_ptr;

    sg_page_bank #(
        .PTR_W     (PTR_W),
        .NUM_PAGES (NUM_PAGES),
        .IDX_W     (IDX_W)
    ) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .ptrs_i (page_ptrs_i),
        .idx_i  (st_q.idx),
        .ptr_o  (cur_ptr)
    );

    sg_step_calc #(
        .PAGE_BITS (PAGE_BITS),
        .NUM_PAGES (NUM_PAGES),
        .IDX_W     (IDX_W),
        .LEN_W     (LEN_W),
        .STEP_W    (STEP_W)
    ) step_i (
        .adv_i      (adv_i),
        .bytes_i    (adv_bytes_i),
        .offset_i   (st_q.offset),
        .idx_i      (st_q.idx),
        .remain_i   (st_q.remain),
        .kind_o     (kind),
        .next_off_o (next_off)
    );

    sg_sat_sub #(
        .W (LEN_W)
    ) sub_i (
        .a_i (st_q.remain),
        .b_i (LEN_W'(adv_bytes_i)),
        .y_o (rem_sub)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.offset = offset_i;
            st_d.idx    = '0;
            st_d.remain = total_i;
            st_d.ovf    = 1'b0;
        end else if (!st_q.ovf) begin
            case (kind)
                ADV_INPAGE: begin
                    st_d.offset = next_off;
                    st_d.remain = rem_sub;
                end
                ADV_CROSS: begin
                    st_d.offset = next_off;
                    st_d.idx    = st_q.idx + IDX_W'(1);
                    st_d.remain = rem_sub;
                end
                ADV_END: begin
                    st_d.remain = '0;
                end
                ADV_ERR: begin
                    st_d.ovf = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o     = {cur_ptr, st_q.offset};
    assign remain_o   = st_q.remain;
    assign page_idx_o = st_q.idx;
    assign done_o     = st_q.remain == '0;
    assign overflow_o = st_q.ovf;

endmodule

// File: rtl/sg_addr_gen_chk.sv
module sg_addr_gen_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int NUM_PAGES = 5,
    parameter int LEN_W     = 15,
    parameter int STEP_W    = PAGE_BITS + 1,
    parameter int IDX_W     = $clog2(NUM_PAGES),
    parameter int PTR_W     = ADDR_W - PAGE_BITS
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load_i,
    input logic [NUM_PAGES*PTR_W-1:0] page_ptrs_i,
    input logic [PAGE_BITS-1:0]       offset_i,
    input logic [LEN_W-1:0]           total_i,
    input logic                       adv_i,
    input logic [STEP_W-1:0]          adv_bytes_i,
    input logic [ADDR_W-1:0]          addr_o,
    input logic [LEN_W-1:0]           remain_o,
    input logic [IDX_W-1:0]           page_idx_o,
    input logic                       done_o,
    input logic                       overflow_o
);

    // R1: a load takes effect on the next edge, whatever the advance input does
    p_load_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (page_idx_o == '0) && (remain_o == $past(total_i)) &&
                   (addr_o[PAGE_BITS-1:0] == $past(offset_i)) && !overflow_o);

    // R4: the page index only ever steps by one, outside of a load
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (page_idx_o == $past(page_idx_o)) ||
                    (page_idx_o == $past(page_idx_o) + IDX_W'(1)));

    // R3: without a load the remaining count never grows
    p_remain_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> remain_o <= $past(remain_o));

    // R5: once the count is exhausted, advances move nothing
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> $stable(addr_o) && $stable(page_idx_o) && done_o);

    // R6: overflow is sticky until a load
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !load_i) |=> overflow_o);

    // R6: with overflow raised the outputs are frozen
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !load_i) |=> $stable(addr_o) && $stable(remain_o) &&
                                    $stable(page_idx_o));

    // R5: done and remaining count agree at all times after reset
    always @(posedge clk) begin
        if (rst_n) begin
            a_done_match_r5: assert (done_o == (remain_o == '0));
        end
    end

endmodule

bind sg_addr_gen sg_addr_gen_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .NUM_PAGES (NUM_PAGES),
    .LEN_W     (LEN_W),
    .STEP_W    (STEP_W),
    .IDX_W     (IDX_W),
    .PTR_W     (PTR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .page_ptrs_i (page_ptrs_i),
    .offset_i    (offset_i),
    .total_i     (total_i),
    .adv_i       (adv_i),
    .adv_bytes_i (adv_bytes_i),
    .addr_o      (addr_o),
    .remain_o    (remain_o),
    .page_idx_o  (page_idx_o),
    .done_o      (done_o),
    .overflow_o  (overflow_o)
);

// File: tb/sg_addr_gen_tb_top.sv
module sg_addr_gen_tb_top;

    localparam int NP  = 5;
    localparam int PW  = 20;
    localparam int NV  = 9;

    typedef struct packed {
        logic [12:0] bytes;
        logic [2:0]  idx;
        logic [11:0] off;
        logic [14:0] rem;
        logic        ovf;
    } vec_t;

    // Walk after loading offset 0xF00, total 16640 bytes (worst-case 16 KB+ span)
    localparam vec_t TBL [NV] = '{
        '{13'h0080, 3'd0, 12'hF80, 15'd16512, 1'b0},  // R3 in-page
        '{13'h0100, 3'd1, 12'h080, 15'd16256, 1'b0},  // R4 crossing
        '{13'h0000, 3'd1, 12'h080, 15'd16256, 1'b0},  // R3 zero bytes
        '{13'h1000, 3'd2, 12'h080, 15'd12160, 1'b0},  // R4 full page step
        '{13'h0F80, 3'd3, 12'h000, 15'd8192,  1'b0},  // R4 lands on page start
        '{13'h1000, 3'd4, 12'h000, 15'd4096,  1'b0},  // R4 into last slot
        '{13'h0800, 3'd4, 12'h800, 15'd2048,  1'b0},  // R3 in last page
        '{13'h0800, 3'd4, 12'h800, 15'd0,     1'b0},  // R7 exact end
        '{13'h0010, 3'd4, 12'h800, 15'd0,     1'b0}   // R5 ignored when done
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [NP*PW-1:0] page_ptrs_i = '0;
    logic [11:0]   offset_i = '0;
    logic [14:0]   total_i = '0;
    logic          adv_i = 1'b0;
    logic [12:0]   adv_bytes_i = '0;
    logic [31:0]   addr_o;
    logic [14:0]   remain_o;
    logic [2:0]    page_idx_o;
    logic          done_o;
    logic          overflow_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    sg_addr_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .page_ptrs_i (page_ptrs_i),
        .offset_i    (offset_i),
        .total_i     (total_i),
        .adv_i       (adv_i),
        .adv_bytes_i (adv_bytes_i),
        .addr_o      (addr_o),
        .remain_o    (remain_o),
        .page_idx_o  (page_idx_o),
        .done_o      (done_o),
        .overflow_o  (overflow_o)
    );

    function automatic logic [19:0] pp(int k);
        return 20'h10000 + 20'(k) * 20'h01001;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(string tag, int idx, logic [11:0] off,
                             logic [14:0] rem, logic ovf);
        chk({tag, " addr"}, addr_o, {pp(idx), off});
        chk({tag, " idx"}, 32'(page_idx_o), 32'(idx));
        chk({tag, " remain"}, 32'(remain_o), 32'(rem));
        chk({tag, " ovf"}, 32'(overflow_o), 32'(ovf));
        chk({tag, " done"}, 32'(done_o), 32'(rem == 0));
    endtask

    task automatic do_load(logic [11:0] off, logic [14:0] tot);
        @(negedge clk);
        load_i = 1'b1; offset_i = off; total_i = tot;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_adv(logic [12:0] b);
        @(negedge clk);
        adv_i = 1'b1; adv_bytes_i = b;
        @(negedge clk);
        adv_i = 1'b0; adv_bytes_i = '0;
    endtask

    initial begin
        for (int k = 0; k < NP; k++) page_ptrs_i[k*PW +: PW] = pp(k);
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 reset addr", addr_o, 32'h0);
        chk("R8 reset remain", 32'(remain_o), 32'h0);
        chk("R8 reset idx", 32'(page_idx_o), 32'h0);
        chk("R8 reset ovf", 32'(overflow_o), 32'h0);
        chk("R8 reset done", 32'(done_o), 32'h1);
        rst_n = 1'b1;

        // R1 / R2: load then table walk
        do_load(12'hF00, 15'd16640);
        chk_state("R1 R2 load", 0, 12'hF00, 15'd16640, 1'b0);
        for (int i = 0; i < NV; i++) begin
            do_adv(TBL[i].bytes);
            chk_state($sformatf("table R3 R4 R5 R7 step %0d", i),
                      int'(TBL[i].idx), TBL[i].off, TBL[i].rem, TBL[i].ovf);
        end

        // R7: full 20 KB from offset 0 ends cleanly
        do_load(12'h000, 15'd20480);
        for (int i = 0; i < 4; i++) do_adv(13'h1000);
        chk_state("R4 four pages", 4, 12'h000, 15'd4096, 1'b0);
        do_adv(13'h1000);
        chk_state("R7 exact 20KB end", 4, 12'h000, 15'd0, 1'b0);

        // R6: oversize advance
        do_load(12'h000, 15'd20480);
        for (int i = 0; i < 4; i++) do_adv(13'h1000);
        do_adv(13'h1001);
        chk_state("R6 oversize", 4, 12'h000, 15'd4096, 1'b1);
        do_adv(13'h0010);
        chk_state("R6 frozen", 4, 12'h000, 15'd4096, 1'b1);

        // R1: reload clears overflow; R3 saturation
        do_load(12'h123, 15'd50);
        chk_state("R1 reload", 0, 12'h123, 15'd50, 1'b0);
        do_adv(13'd100);
        chk_state("R3 saturate", 0, 12'h187, 15'd0, 1'b0);

        // R6: sixth page needed from non-zero start
        do_load(12'h100, 15'd20480);
        for (int i = 0; i < 4; i++) do_adv(13'h1000);
        chk_state("R4 offset start walk", 4, 12'h100, 15'd4096, 1'b0);
        do_adv(13'h0F00);
        chk_state("R6 sixth page", 4, 12'h100, 15'd4096, 1'b1);

        // R1: load and advance in the same cycle, load wins
        @(negedge clk);
        load_i = 1'b1; offset_i = 12'h010; total_i = 15'd300;
        adv_i = 1'b1; adv_bytes_i = 13'h020;
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0; adv_bytes_i = '0;
        chk_state("R1 load beats advance", 0, 12'h010, 15'd300, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R1 R8: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule